// File: doc/BRIEF.md
# Complementary Half-Bridge Gate Sequencer

This block turns a train of single-cycle oscillator pulses into the two gate commands of a fixed-frequency, peak-current-mode half-bridge. The pulses are split alternately into even and odd ones, so one switching period spans two oscillator periods. An even pulse ends the low-side conduction. After a programmable dead time the high-side gate rises. The high side stays on until the PWM comparator trips, the first-level current-limit comparator trips, or the next odd pulse arrives, whichever comes first. The low side follows one dead time after that. Because the high side can only start after a dead time that follows an even pulse, and must end by the next odd pulse, its duty stays below one half.

Before the first high-side pulse, the sequencer charges the bootstrap capacitor by holding the low side on. On a cold start it holds it for a parameterised number of oscillator periods. On a restart after a burst idle it holds it for a single period. The comparator inputs are ignored for a fixed blanking window after each high-side turn-on. Only one high-side turn-off is allowed per switching period, so a noisy comparator cannot produce a second pulse. The dead time comes from a value in system-clock cycles and is never shorter than a built-in floor. Dropping the enable input parks both gates low.

Top module: `hb_pwm_seq`

## Requirements
- R1: While reset is asserted, and from the first clock edge at which `enable` is sampled low, both gates are low. Oscillator pulses and comparator trips seen while disabled leave both gates low.
- R2: `hs_gate` and `ls_gate` are never high in the same cycle.
- R3: With `burst_resume` low at the first oscillator pulse after enabling, `ls_gate` rises after that pulse's edge. It falls at the edge of the PRECHARGE_PULSES-th pulse that follows, so it stays high for PRECHARGE_PULSES oscillator periods. `hs_gate` stays low throughout.
- R4: With `burst_resume` high at the first oscillator pulse after enabling, `ls_gate` rises at that pulse and falls at the very next pulse.
- R5: The pulse that ends the precharge counts as even, and later pulses alternate odd, even. An even pulse seen while `ls_gate` is high drops `ls_gate` after that edge. `hs_gate` rises exactly one effective dead time (in clock edges) later.
- R6: `hs_gate` falls after the first edge at which an unblanked `pwm_trip` or an unblanked `ilim_trip` is high, or at which an odd pulse is seen. `ls_gate` rises exactly one effective dead time later.
- R7: Both trip inputs are ignored during the first BLANK_CYC cycles that `hs_gate` is high. A trip first takes effect when sampled in the high-side cycle with index BLANK_CYC, counting the first high cycle as 0.
- R8: Once `hs_gate` has fallen in a switching period, it does not rise again before the next even pulse, whatever the trip inputs do.
- R9: The effective dead time is `dead_cycles` or DT_MIN_CYC, whichever is larger. It applies to both transitions.
- R10: Odd pulses never start a high-side pulse. After the precharge, 2·M oscillator pulses give exactly M high-side pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request; low parks both gates |
| osc_pulse | input | 1 | Single-cycle oscillator clock pulse |
| burst_resume | input | 1 | High at the first pulse when restarting from burst idle |
| pwm_trip | input | 1 | PWM comparator decision, synchronous |
| ilim_trip | input | 1 | First-level current-limit comparator decision, synchronous |
| dead_cycles | input | DT_W | Requested dead time in clock cycles |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |

## Verification
A wrong even/odd phase shows up within one switching period. The high side would start on an odd pulse, and the count of high-side pulses per run would no longer equal half the post-precharge pulses. A dead-time or blanking counter that is off by one moves a gate edge by one clock, which the edge-to-edge gap and width measurements catch on the first pulse. A precharge counter or burst flag that is wrong changes the length of the first low-side interval, which is seen before any high-side pulse.

// File: rtl/hb_pwm_seq.sv
module hb_pwm_seq #(
  parameter int DT_W             = 8,
  parameter int DT_MIN_CYC       = 33,
  parameter int BLANK_CYC        = 20,
  parameter int PRECHARGE_PULSES = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            osc_pulse,
  input  logic            burst_resume,
  input  logic            pwm_trip,
  input  logic            ilim_trip,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            hs_gate,
  output logic            ls_gate
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int PW = $clog2(PRECHARGE_PULSES + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LS, S_DT_LH, S_HS, S_DT_HL} st_t;

  st_t             st;
  logic [DT_W-1:0] dt_cnt;
  logic [BW-1:0]   blk_cnt;
  logic [PW-1:0]   pre_cnt;
  logic [PW-1:0]   pre_goal;
  logic            odd_next;

  logic [DT_W-1:0] dt_eff;
  logic            trip_ok;
  logic            even_pls;
  logic            odd_pls;

  assign dt_eff   = (dead_cycles < DT_W'(DT_MIN_CYC)) ? DT_W'(DT_MIN_CYC) : dead_cycles;
  assign trip_ok  = (blk_cnt == '0) && (pwm_trip || ilim_trip);
  assign even_pls = osc_pulse && !odd_next;
  assign odd_pls  = osc_pulse && odd_next;

  assign hs_gate = (st == S_HS);
  assign ls_gate = (st == S_LS) || (st == S_PRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      dt_cnt   <= '0;
      blk_cnt  <= '0;
      pre_cnt  <= '0;
      pre_goal <= '0;
      odd_next <= 1'b0;
    end else if (!enable) begin
      st       <= S_IDLE;
      dt_cnt   <= '0;
      blk_cnt  <= '0;
      pre_cnt  <= '0;
      odd_next <= 1'b0;
    end else begin
      if (osc_pulse && st != S_IDLE && st != S_PRE)
        odd_next <= ~odd_next;
      case (st)
        S_IDLE: begin
          if (osc_pulse) begin
            st       <= S_PRE;
            pre_cnt  <= '0;
            pre_goal <= burst_resume ? PW'(1) : PW'(PRECHARGE_PULSES);
          end
        end
        S_PRE: begin
          if (osc_pulse) begin
            if (pre_cnt + PW'(1) == pre_goal) begin
              st       <= S_DT_LH;
              dt_cnt   <= dt_eff - DT_W'(1);
              odd_next <= 1'b1;
            end else begin
              pre_cnt <= pre_cnt + PW'(1);
            end
          end
        end
        S_LS: begin
          if (even_pls) begin
            st     <= S_DT_LH;
            dt_cnt <= dt_eff - DT_W'(1);
          end
        end
        S_DT_LH: begin
          if (odd_pls) begin
            st     <= S_DT_HL;
            dt_cnt <= dt_eff - DT_W'(1);
          end else if (dt_cnt == '0) begin
            st      <= S_HS;
            blk_cnt <= BW'(BLANK_CYC);
          end else begin
            dt_cnt <= dt_cnt - DT_W'(1);
          end
        end
        S_HS: begin
          if (odd_pls || trip_ok) begin
            st     <= S_DT_HL;
            dt_cnt <= dt_eff - DT_W'(1);
          end else if (blk_cnt != '0) begin
            blk_cnt <= blk_cnt - BW'(1);
          end
        end
        S_DT_HL: begin
          if (dt_cnt == '0) st <= S_LS;
          else              dt_cnt <= dt_cnt - DT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hb_pwm_seq_chk.sv
module hb_pwm_seq_chk #(
  parameter int DT_MIN_CYC = 33,
  parameter int BLANK_CYC  = 20
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic osc_pulse,
  input logic hs_gate,
  input logic ls_gate
);
  logic [15:0] gap;
  logic [15:0] hs_age;
  logic        hs_last;
  logic        hs_spent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap      <= '0;
      hs_age   <= '0;
      hs_last  <= 1'b0;
      hs_spent <= 1'b0;
    end else begin
      gap    <= (hs_gate || ls_gate) ? 16'd0 : ((gap == 16'hFFFF) ? gap : gap + 16'd1);
      hs_age <= hs_gate ? ((hs_age == 16'hFFFF) ? hs_age : hs_age + 16'd1) : 16'd0;
      if (!enable || ls_gate) hs_last <= 1'b0;
      else if (hs_gate)       hs_last <= 1'b1;
      if (ls_gate)                         hs_spent <= 1'b0;
      else if (!hs_gate && hs_age != 16'd0) hs_spent <= 1'b1;
    end
  end

  a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hs_gate && !ls_gate));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  a_r9_hs_dead_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> (gap >= 16'(DT_MIN_CYC)));

  a_r6_ls_dead_floor: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ls_gate) && hs_last) |-> (gap >= 16'(DT_MIN_CYC)));

  a_r7_blanking: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hs_gate && hs_age < 16'(BLANK_CYC) && !osc_pulse) |=> hs_gate);

  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_gate) |-> !hs_spent);
endmodule

bind hb_pwm_seq hb_pwm_seq_chk #(
  .DT_MIN_CYC(DT_MIN_CYC),
  .BLANK_CYC (BLANK_CYC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .osc_pulse(osc_pulse),
  .hs_gate  (hs_gate),
  .ls_gate  (ls_gate)
);

// File: tb/hb_pwm_seq_tb_top.sv
module hb_pwm_seq_tb_top;
  localparam int DT_W  = 8;
  localparam int DTMIN = 33;
  localparam int BLANK = 20;
  localparam int PRE   = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            enable = 1'b0;
  logic            osc_pulse = 1'b0;
  logic            burst_resume = 1'b0;
  logic            pwm_trip = 1'b0;
  logic            ilim_trip = 1'b0;
  logic [DT_W-1:0] dead_cycles = '0;
  logic            hs_gate;
  logic            ls_gate;

  hb_pwm_seq #(.DT_W(DT_W), .DT_MIN_CYC(DTMIN), .BLANK_CYC(BLANK), .PRECHARGE_PULSES(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .osc_pulse(osc_pulse),
    .burst_resume(burst_resume), .pwm_trip(pwm_trip), .ilim_trip(ilim_trip),
    .dead_cycles(dead_cycles), .hs_gate(hs_gate), .ls_gate(ls_gate));

  always #5 clk = ~clk;

  int checks = 0, errs = 0;
  bit done = 0;
  int cyc = 0, overlap = 0, hs_cnt = 0;
  int t_lsf = 0, t_lsr = 0, t_hsr = 0, t_hsf = 0;
  int cur_eff = 0, cur_w = 0, exp_pre = 0;
  bit mon_on = 0, arm_first = 0, in_pre = 0, p_hs = 0, p_ls = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_dt(int d);
    return (d < DTMIN) ? DTMIN : d;
  endfunction

  function automatic int exp_width(int a, int p, int e, int mode);
    if (mode != 0 && a > BLANK && a <= p - e) return a;
    return p - e;
  endfunction

  always @(posedge clk) begin
    #1;
    cyc++;
    if (mon_on) begin
      if (hs_gate && ls_gate) overlap++;
      if (ls_gate && !p_ls) begin
        if (arm_first) begin t_lsr = cyc; in_pre = 1; arm_first = 0; end
        else chk("R6 low-side rise after dead time", cyc - t_hsf, cur_eff);
      end
      if (!ls_gate && p_ls) begin
        if (in_pre) begin chk("R3/R4 precharge length", cyc - t_lsr, exp_pre); in_pre = 0; end
        t_lsf = cyc;
      end
      if (hs_gate && !p_hs) begin
        chk("R5/R9 high-side rise after dead time", cyc - t_lsf, cur_eff);
        hs_cnt++;
        t_hsr = cyc;
      end
      if (!hs_gate && p_hs) begin
        chk("R6/R7 high-side width", cyc - t_hsr, cur_w);
        t_hsf = cyc;
      end
    end
    p_hs = hs_gate;
    p_ls = ls_gate;
  end

  // mode 0: no trips, 1: single trip pulse at age a, 2: trip held from age a (R8)
  task automatic run(int p, int d, bit burst, int m, int mode, int a, bit use_ilim);
    int age = 0;
    int np;
    int stuck = 0;
    bit tr;
    dead_cycles  = DT_W'(d);
    burst_resume = burst;
    cur_eff = eff_dt(d);
    cur_w   = exp_width(a, p, cur_eff, mode);
    exp_pre = (burst ? 1 : PRE) * p;
    hs_cnt  = 0;
    arm_first = 1;
    in_pre = 0;
    @(negedge clk);
    mon_on = 1;
    enable = 1;
    np = (burst ? 1 : PRE) + 2 * m;
    for (int i = 0; i < np; i++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        osc_pulse = (c == 0);
        if (hs_gate) age++; else age = 0;
        case (mode)
          1: tr = hs_gate && (age == a);
          2: tr = !hs_gate || (age >= a);
          default: tr = 1'b0;
        endcase
        pwm_trip  = tr && !use_ilim;
        ilim_trip = tr && use_ilim;
      end
    end
    chk("R8/R10 high-side pulses per run", hs_cnt, m);
    @(negedge clk);
    mon_on = 0;
    enable = 0;
    osc_pulse = 0;
    pwm_trip = 1;
    ilim_trip = 1;
    @(posedge clk); #1;
    chk("R1 gates low after disable", int'(hs_gate) + int'(ls_gate), 0);
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      osc_pulse = (c % 3 == 0);
      @(posedge clk); #1;
      if (hs_gate || ls_gate) stuck++;
    end
    chk("R1 pulses ignored while disabled", stuck, 0);
    @(negedge clk);
    osc_pulse = 0;
    pwm_trip = 0;
    ilim_trip = 0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset state", int'(hs_gate) + int'(ls_gate), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    run(120, 0, 0, 3, 0, 0, 0);           // R3 cold start, R9 floor applies
    run(150, 50, 1, 3, 1, 10, 0);         // R4 burst, R7 blanked trip
    run(100, 33, 1, 2, 1, BLANK + 1, 0);  // R7 first unblanked cycle
    run(100, 5, 1, 2, 2, 30, 1);          // R8 held current-limit trip
    run(130, 40, 0, 2, 1, 45, 1);         // R6 current-limit trip

    for (int k = 0; k < 8; k++) begin
      int d = $urandom_range(70, 0);
      int e = eff_dt(d);
      int p = 2 * e + BLANK + 5 + $urandom_range(40, 0);
      int mode = $urandom_range(2, 0);
      int a = (mode == 2) ? $urandom_range(p - e, BLANK + 1) : $urandom_range(p - e, 1);
      run(p, d, $urandom_range(1, 0), $urandom_range(4, 1), mode, a, $urandom_range(1, 0));
    end

    chk("R2 gates never overlap", overlap, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule